// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes up to sixteen interrupt request lines to processor-side delivery messages. Each line has a 64-bit routing entry that holds a vector, a destination ID, a mask bit, a trigger-mode bit, a destination-mode bit and a delivery-mode field. Software cannot address the entries directly. It first writes an internal register number into a selector register, then reads or writes the chosen register through a single data window. Each 64-bit entry is therefore seen as two 32-bit registers.

The block only reacts when a request line changes level. When a line rises and its entry permits delivery, the block queues one message for that line. Messages leave through a valid/ready output. A line that rises while its entry is masked and set to level trigger is remembered as pending. It is delivered later if software unmasks the entry while the line is still high.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: The register port accepts only accesses with size code 2 (four bytes) at offset 0x00 (selector) or 0x10 (window). Any other write changes no state, and any other read returns 0. Read data is combinational in the access cycle.
- R2: A read at 0x00 returns the full 32-bit selector value last written. A window access targets the internal register numbered by selector bits 7:0 only.
- R3: Internal register 0x00 keeps only bits 27:24 of written data, and all its other bits read 0. Register 0x01 reads 0x00100011 (entry count 16 in bits 23:16, 0x11 in bits 7:0) and ignores writes. Register 0x02 reads the same value as register 0x00 and ignores writes. Every other register outside the table reads 0 and ignores writes.
- R4: Line p's entry bits 31:0 sit at register 0x10+2p and bits 63:32 at 0x11+2p. A write replaces only the addressed half. After reset every entry is 0x0001000000010000.
- R5: Only a low-to-high change of a line (seen against the level recorded on the previous clock) can start a delivery. A line held high, or a falling line, sends nothing.
- R6: A rising line queues a message only when its entry has bit 16 (mask) = 0, bit 11 (destination mode) = 0 and bits 10:8 (delivery mode) = 000. The message carries vector = entry bits 7:0 and destination = entry bits 63:56. With the output idle, valid rises after the second clock edge that samples the line high.
- R7: The broadcast output is 1 exactly when the delivered destination is 0xFF.
- R8: A line that rises while its entry has bit 16 = 1 and bit 15 (level trigger) = 1 becomes pending. A masked edge-triggered entry (bit 15 = 0) does not become pending.
- R9: A window write that leaves a pending entry with bit 16 = 0 clears the pending state. If the line is high at that write, a message is queued as if the line had risen. If the line is low, nothing is sent.
- R10: Valid and the payload stay constant until ready is seen. At most one request is held per line, and held requests leave lowest line number first. The payload is taken from the entry at the moment the message is loaded into the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 2 | Access size code (2 = four bytes) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_lines | input | 16 | Interrupt request levels, one per line |
| dlv_valid | output | 1 | Delivery message available |
| dlv_ready | input | 1 | Receiver accepts the message |
| dlv_vector | output | 8 | Vector of the message |
| dlv_dest | output | 8 | Destination ID of the message |
| dlv_bcast | output | 1 | Message is a broadcast |

## Verification
A wrong recorded line level shows up within two clocks as a missing or duplicated message, because delivery depends only on that recorded level. A corrupted entry half or selector value shows up at the very next window read, and also in the vector or destination of the next message for that line. A stale pending flag stays hidden until software unmasks the entry. It then produces a message that should not exist, or fails to produce one that should, two clocks after the write. The reference model is therefore compared with the outputs on every clock, under random unmask writes and random line toggling.

// File: rtl/irq_redir_pkg.sv
`timescale 1ns/1ps
// Shared constants and message type for the interrupt redirection controller.
// Assumes 64-bit routing entries and an 8-bit internal register number.
package irq_redir_pkg;
    localparam int MASK_BIT  = 16;
    localparam int TRIG_BIT  = 15;
    localparam int DMODE_BIT = 11;
    localparam int DLV_LO    = 8;
    localparam int DLV_HI    = 10;
    localparam logic [63:0] ENTRY_RESET = 64'h0001_0000_0001_0000;
    localparam logic [7:0]  REG_ID   = 8'h00;
    localparam logic [7:0]  REG_VER  = 8'h01;
    localparam logic [7:0]  REG_ARB  = 8'h02;
    localparam logic [7:0]  TBL_BASE = 8'h10;
    localparam logic [7:0]  VER_CODE = 8'h11;
    localparam logic [7:0]  DEST_ALL = 8'hFF;

    typedef struct packed {
        logic [7:0] vector;
        logic [7:0] dest;
        logic       bcast;
    } dlv_msg_t;
endpackage

// File: rtl/irq_reg_port.sv
`timescale 1ns/1ps
// Register port: decodes the selector and window offsets, holds the selector,
// and turns window accesses into internal register reads and writes.
// Assumes a single-cycle access strobe; read data is combinational.
module irq_reg_port #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              win_we,
    output logic [7:0]        win_idx,
    output logic [DATA_W-1:0] win_wdata,
    input  logic [DATA_W-1:0] win_rdata
);
    localparam logic [ADDR_W-1:0] OFS_SEL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_WIN = ADDR_W'(16);
    localparam logic [1:0]        SIZE_OK = 2'd2;

    logic [DATA_W-1:0] sel_q;
    logic acc_ok, hit_sel, hit_win;

    // Qualify the access by size and offset.
    always_comb begin
        acc_ok  = bus_req && (bus_size == SIZE_OK);
        hit_sel = acc_ok && (bus_addr == OFS_SEL);
        hit_win = acc_ok && (bus_addr == OFS_WIN);
    end

    // Selector register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (hit_sel && bus_we)
            sel_q <= bus_wdata;
    end

    // Window strobes and read data steering.
    always_comb begin
        win_we    = hit_win && bus_we;
        win_idx   = sel_q[7:0];
        win_wdata = bus_wdata;
        if (hit_sel && !bus_we)
            bus_rdata = sel_q;
        else if (hit_win && !bus_we)
            bus_rdata = win_rdata;
        else
            bus_rdata = '0;
    end

    // R1: a rejected write leaves the selector untouched.
    assert_bad_write_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !acc_ok) |=> $stable(sel_q));
endmodule

// File: rtl/irq_redir_table.sv
`timescale 1ns/1ps
// Routing table, ID register, line level tracking and pending flags.
// Emits a one-cycle request per line when a message must be queued.
// Assumes 2*NUM_PINS entries fit above register 0x10 in an 8-bit index.
module irq_redir_table
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     win_we,
    input  logic [7:0]               win_idx,
    input  logic [31:0]              win_wdata,
    output logic [31:0]              win_rdata,
    input  logic [NUM_PINS-1:0]      irq_lines,
    output logic [NUM_PINS-1:0]      fire,
    output logic [NUM_PINS-1:0][7:0] ent_vec,
    output logic [NUM_PINS-1:0][7:0] ent_dest
);
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int TBL_REGS = 2 * NUM_PINS;
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS), 8'h00, VER_CODE};

    logic [NUM_PINS-1:0][63:0] entry_q;
    logic [NUM_PINS-1:0]       pend_q;
    logic [NUM_PINS-1:0]       line_q;
    logic [NUM_PINS-1:0]       wr_hit;
    logic [3:0]                id_q;
    logic [7:0]                tbl_off;
    logic                      tbl_hit;
    logic [PIN_W-1:0]          tbl_pin;
    logic                      tbl_hi;

    // Decode the window index into table line and half.
    always_comb begin
        tbl_off = win_idx - TBL_BASE;
        tbl_hit = (win_idx >= TBL_BASE) && ({1'b0, tbl_off} < 9'(TBL_REGS));
        tbl_pin = tbl_off[PIN_W:1];
        tbl_hi  = tbl_off[0];
    end

    // ID register keeps its four defined bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= '0;
        else if (win_we && win_idx == REG_ID)
            id_q <= win_wdata[27:24];
    end

    // Window read multiplexer.
    always_comb begin
        win_rdata = '0;
        if (win_idx == REG_ID || win_idx == REG_ARB)
            win_rdata = {4'b0, id_q, 24'b0};
        else if (win_idx == REG_VER)
            win_rdata = VER_WORD;
        else if (tbl_hit)
            win_rdata = tbl_hi ? entry_q[tbl_pin][63:32] : entry_q[tbl_pin][31:0];
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_line
        logic [63:0] eff;
        logic rise, can_send, held_level, unmask_evt, rerun;

        // Post-write view of the entry and the decisions taken on it.
        always_comb begin
            wr_hit[p] = win_we && tbl_hit && (tbl_pin == PIN_W'(p));
            eff = entry_q[p];
            if (wr_hit[p]) begin
                if (tbl_hi) eff[63:32] = win_wdata;
                else        eff[31:0]  = win_wdata;
            end
            rise       = irq_lines[p] && !line_q[p];
            can_send   = !eff[MASK_BIT] && !eff[DMODE_BIT] && (eff[DLV_HI:DLV_LO] == 3'b000);
            held_level = eff[MASK_BIT] && eff[TRIG_BIT];
            unmask_evt = wr_hit[p] && pend_q[p] && !eff[MASK_BIT];
            rerun      = unmask_evt && irq_lines[p];
            fire[p]    = (rise || rerun) && can_send;
            ent_vec[p]  = entry_q[p][7:0];
            ent_dest[p] = entry_q[p][63:56];
        end

        // Entry, pending flag and recorded line level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[p] <= ENTRY_RESET;
                pend_q[p]  <= 1'b0;
                line_q[p]  <= 1'b0;
            end else begin
                entry_q[p] <= eff;
                line_q[p]  <= irq_lines[p];
                if (unmask_evt)
                    pend_q[p] <= 1'b0;
                else if (rise && held_level)
                    pend_q[p] <= 1'b1;
            end
        end

        // R8: a pending line always has a masked entry.
        assert_pend_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q[p] |-> entry_q[p][MASK_BIT]);
        // R5: a line already recorded high sends nothing without an unmask write.
        assert_no_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (line_q[p] && irq_lines[p] && !wr_hit[p]) |-> !fire[p]);
    end
endmodule

// File: rtl/irq_dispatch.sv
`timescale 1ns/1ps
// Request holding and output stage: one request bit per line, lowest line
// granted first, message payload read from the entry at load time.
// Assumes the receiver follows a plain valid/ready rule.
module irq_dispatch
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PINS-1:0]      fire,
    input  logic [NUM_PINS-1:0][7:0] ent_vec,
    input  logic [NUM_PINS-1:0][7:0] ent_dest,
    input  logic                     dlv_ready,
    output logic                     dlv_valid,
    output dlv_msg_t                 dlv_msg
);
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NUM_PINS-1:0] req_q, grant;
    logic [PIN_W-1:0]    gidx;
    logic                found, free;

    // Lowest-numbered held request wins the output when it is free.
    always_comb begin
        free  = !dlv_valid || dlv_ready;
        found = 1'b0;
        gidx  = '0;
        grant = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (!found && req_q[i]) begin
                found = 1'b1;
                gidx  = PIN_W'(i);
            end
        end
        if (free && found)
            grant[gidx] = 1'b1;
    end

    // Held requests: drop the granted one, add new ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= '0;
        else
            req_q <= (req_q & ~grant) | fire;
    end

    // Output register loads when empty or accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid <= 1'b0;
            dlv_msg   <= '0;
        end else if (free) begin
            dlv_valid <= found;
            if (found)
                dlv_msg <= '{vector: ent_vec[gidx], dest: ent_dest[gidx],
                             bcast: (ent_dest[gidx] == DEST_ALL)};
        end
    end

    // R10: a stalled message holds its payload.
    assert_hold_until_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_msg)));
    // R10: valid only drops after an accepted message.
    assert_drop_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dlv_valid) |-> $past(dlv_ready));
    // R7: broadcast flag agrees with the destination on the output.
    assert_bcast_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_msg.bcast == (dlv_msg.dest == DEST_ALL)));
endmodule

// File: rtl/irq_redirect_ctrl.sv
`timescale 1ns/1ps
// Top of the interrupt redirection controller: register port, routing table
// and dispatch stage. Assumes all inputs are synchronous to clk.
module irq_redirect_ctrl
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [1:0]          bus_size,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] irq_lines,
    output logic                dlv_valid,
    input  logic                dlv_ready,
    output logic [7:0]          dlv_vector,
    output logic [7:0]          dlv_dest,
    output logic                dlv_bcast
);
    logic                     win_we;
    logic [7:0]               win_idx;
    logic [31:0]              win_wdata, win_rdata;
    logic [NUM_PINS-1:0]      fire;
    logic [NUM_PINS-1:0][7:0] ent_vec, ent_dest;
    dlv_msg_t                 msg;

    irq_reg_port #(.ADDR_W(ADDR_W), .DATA_W(32)) u_port (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .win_we(win_we), .win_idx(win_idx),
        .win_wdata(win_wdata), .win_rdata(win_rdata)
    );

    irq_redir_table #(.NUM_PINS(NUM_PINS)) u_table (
        .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_idx(win_idx),
        .win_wdata(win_wdata), .win_rdata(win_rdata), .irq_lines(irq_lines),
        .fire(fire), .ent_vec(ent_vec), .ent_dest(ent_dest)
    );

    irq_dispatch #(.NUM_PINS(NUM_PINS)) u_dispatch (
        .clk(clk), .rst_n(rst_n), .fire(fire), .ent_vec(ent_vec),
        .ent_dest(ent_dest), .dlv_ready(dlv_ready), .dlv_valid(dlv_valid),
        .dlv_msg(msg)
    );

    // Unpack the message onto the output pins.
    always_comb begin
        dlv_vector = msg.vector;
        dlv_dest   = msg.dest;
        dlv_bcast  = msg.bcast;
    end
endmodule

// File: tb/irq_redirect_ctrl_bench.sv
`timescale 1ns/1ps
module irq_redirect_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_lines = '0;
    logic        dlv_ready = 1'b1;
    logic        dlv_valid, dlv_bcast;
    logic [7:0]  dlv_vector, dlv_dest;

    int checks = 0, fails = 0;
    bit started = 0, finished = 0;

    // reference model state
    logic [63:0] m_ent [16];
    logic [15:0] m_pend, m_pin, m_req;
    logic [31:0] m_sel;
    logic [3:0]  m_id;
    logic        m_valid, m_bc;
    logic [7:0]  m_vec, m_dest;

    // delivery log
    logic [7:0] lg_vec [$];
    logic [7:0] lg_dest [$];
    logic       lg_bc [$];

    irq_redirect_ctrl u_irq_redirect_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_lines(irq_lines), .dlv_valid(dlv_valid),
        .dlv_ready(dlv_ready), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
        .dlv_bcast(dlv_bcast)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] reg_value(input logic [7:0] idx);
        if (idx == 8'h00 || idx == 8'h02) return {4'b0, m_id, 24'b0};
        if (idx == 8'h01) return 32'h0010_0011;
        if (idx >= 8'h10 && idx < 8'h30)
            return idx[0] ? m_ent[(idx - 8'h10) >> 1][63:32] : m_ent[(idx - 8'h10) >> 1][31:0];
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_rdata();
        if (!bus_req || bus_we || bus_size != 2'd2) return 32'h0;
        if (bus_addr == 8'h00) return m_sel;
        if (bus_addr == 8'h10) return reg_value(m_sel[7:0]);
        return 32'h0;
    endfunction

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_ent[i] = 64'h0001_0000_0001_0000;
            m_pend = '0; m_pin = '0; m_req = '0; m_sel = '0; m_id = '0;
            m_valid = 0; m_bc = 0; m_vec = '0; m_dest = '0;
        end else begin
            logic [15:0] wr_pin;
            logic [7:0] idx;
            if (m_valid && dlv_ready) begin
                lg_vec.push_back(m_vec); lg_dest.push_back(m_dest); lg_bc.push_back(m_bc);
            end
            if (!m_valid || dlv_ready) begin
                m_valid = 0;
                for (int i = 0; i < 16; i++) begin
                    if (!m_valid && m_req[i]) begin
                        m_valid = 1; m_req[i] = 0;
                        m_vec = m_ent[i][7:0]; m_dest = m_ent[i][63:56];
                        m_bc = (m_dest == 8'hFF);
                    end
                end
            end
            wr_pin = '0;
            if (bus_req && bus_we && bus_size == 2'd2) begin
                if (bus_addr == 8'h00) m_sel = bus_wdata;
                else if (bus_addr == 8'h10) begin
                    idx = m_sel[7:0];
                    if (idx == 8'h00) m_id = bus_wdata[27:24];
                    else if (idx >= 8'h10 && idx < 8'h30) begin
                        if (idx[0]) m_ent[(idx - 8'h10) >> 1][63:32] = bus_wdata;
                        else        m_ent[(idx - 8'h10) >> 1][31:0]  = bus_wdata;
                        wr_pin[(idx - 8'h10) >> 1] = 1'b1;
                    end
                end
            end
            for (int p = 0; p < 16; p++) begin
                logic lvl, rise, ok, again;
                logic [63:0] e;
                e = m_ent[p]; lvl = irq_lines[p]; rise = lvl && !m_pin[p]; again = 0;
                ok = !e[16] && !e[11] && (e[10:8] == 3'b000);
                if (wr_pin[p] && m_pend[p] && !e[16]) begin
                    m_pend[p] = 0;
                    again = lvl;
                end
                if ((rise || again) && ok) m_req[p] = 1;
                if (rise && e[16] && e[15]) m_pend[p] = 1;
                m_pin[p] = lvl;
            end
        end
        started = 1;
    end

    // Compare outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            check("R10 valid", 32'(dlv_valid), 32'(m_valid));
            if (m_valid) begin
                check("R6 vector", 32'(dlv_vector), 32'(m_vec));
                check("R6 dest", 32'(dlv_dest), 32'(m_dest));
                check("R7 bcast", 32'(dlv_bcast), 32'(m_bc));
            end
            check("R1/R2 rdata", bus_rdata, exp_rdata());
        end
    end

    task automatic access(input logic we, input logic [7:0] addr, input logic [1:0] size,
                          input logic [31:0] data, output logic [31:0] rd);
        @(posedge clk); #2;
        bus_req = 1; bus_we = we; bus_addr = addr; bus_size = size; bus_wdata = data;
        @(negedge clk); rd = bus_rdata;
        @(posedge clk); #2;
        bus_req = 0; bus_we = 0; bus_size = 2'd2;
    endtask

    task automatic wreg(input logic [7:0] idx, input logic [31:0] data);
        logic [31:0] d;
        access(1, 8'h00, 2'd2, {24'h0, idx}, d);
        access(1, 8'h10, 2'd2, data, d);
    endtask

    task automatic rreg(input logic [7:0] idx, output logic [31:0] rd);
        logic [31:0] d;
        access(1, 8'h00, 2'd2, {24'h0, idx}, d);
        access(0, 8'h10, 2'd2, 32'h0, rd);
    endtask

    task automatic line(input int p, input logic v);
        @(posedge clk); #2; irq_lines[p] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clear_log();
        lg_vec.delete(); lg_dest.delete(); lg_bc.delete();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        check("R10 reset valid", 32'(dlv_valid), 32'h0);

        // R4 reset values and half mapping
        rreg(8'h10, rd); check("R4 reset lo", rd, 32'h0001_0000);
        rreg(8'h11, rd); check("R4 reset hi", rd, 32'h0001_0000);
        rreg(8'h2F, rd); check("R4 reset last hi", rd, 32'h0001_0000);

        // R3 identification registers
        rreg(8'h01, rd); check("R3 version", rd, 32'h0010_0011);
        wreg(8'h01, 32'hFFFF_FFFF);
        rreg(8'h01, rd); check("R3 version write ignored", rd, 32'h0010_0011);
        wreg(8'h00, 32'hFFFF_FFFF);
        rreg(8'h00, rd); check("R3 id bits", rd, 32'h0F00_0000);
        rreg(8'h02, rd); check("R3 arb mirrors id", rd, 32'h0F00_0000);
        wreg(8'h05, 32'h1234_5678);
        rreg(8'h05, rd); check("R3 undefined reg", rd, 32'h0);

        // R2 selector readback and low-byte decode
        access(1, 8'h00, 2'd2, 32'h1234_5678, rd);
        access(0, 8'h00, 2'd2, 32'h0, rd); check("R2 selector readback", rd, 32'h1234_5678);
        access(0, 8'h10, 2'd2, 32'h0, rd); check("R2 low byte 0x78 undefined", rd, 32'h0);
        access(1, 8'h00, 2'd2, 32'h0000_0101, rd);
        access(0, 8'h10, 2'd2, 32'h0, rd); check("R2 low byte selects version", rd, 32'h0010_0011);

        // R1 rejected accesses
        access(1, 8'h00, 2'd1, 32'h0000_0033, rd);
        access(0, 8'h00, 2'd2, 32'h0, rd); check("R1 narrow write ignored", rd, 32'h0000_0101);
        access(1, 8'h04, 2'd2, 32'h0000_0033, rd);
        access(0, 8'h00, 2'd2, 32'h0, rd); check("R1 bad offset write ignored", rd, 32'h0000_0101);
        access(0, 8'h04, 2'd2, 32'h0, rd); check("R1 bad offset read", rd, 32'h0);
        access(0, 8'h10, 2'd3, 32'h0, rd); check("R1 wide read", rd, 32'h0);

        // R6/R5 basic unicast delivery on pin 3
        wreg(8'h16, 32'h0000_0041);
        wreg(8'h17, 32'h0500_0000);
        rreg(8'h16, rd); check("R4 lo written", rd, 32'h0000_0041);
        clear_log();
        line(3, 1); idle(6);
        check("R6 one delivery", lg_vec.size(), 1);
        if (lg_vec.size() > 0) begin
            check("R6 vector", 32'(lg_vec[0]), 32'h41);
            check("R6 dest", 32'(lg_dest[0]), 32'h05);
            check("R7 unicast", 32'(lg_bc[0]), 32'h0);
        end
        clear_log(); idle(5);
        check("R5 held high sends nothing", lg_vec.size(), 0);
        line(3, 0); idle(5);
        check("R5 fall sends nothing", lg_vec.size(), 0);
        line(3, 1); idle(6);
        check("R5 new rise delivers", lg_vec.size(), 1);
        line(3, 0);

        // R4 half write keeps other half
        wreg(8'h17, 32'h0900_0000);
        rreg(8'h16, rd); check("R4 lo kept", rd, 32'h0000_0041);

        // R7 broadcast
        wreg(8'h18, 32'h0000_0044);
        wreg(8'h19, 32'hFF00_0000);
        clear_log(); line(4, 1); idle(6); line(4, 0);
        check("R7 bcast count", lg_vec.size(), 1);
        if (lg_bc.size() > 0) check("R7 bcast flag", 32'(lg_bc[0]), 32'h1);

        // R8/R9 masked level re-delivered on unmask
        wreg(8'h1C, 32'h0001_8062);
        wreg(8'h1D, 32'h0200_0000);
        clear_log(); line(6, 1); idle(5);
        check("R8 masked level silent", lg_vec.size(), 0);
        wreg(8'h1C, 32'h0000_8062); idle(5);
        check("R9 unmask redelivers", lg_vec.size(), 1);
        if (lg_vec.size() > 0) check("R9 vector", 32'(lg_vec[0]), 32'h62);
        line(6, 0);

        // R9 pending but line low on unmask: nothing
        wreg(8'h1E, 32'h0001_8067);
        clear_log(); line(7, 1); idle(2); line(7, 0); idle(2);
        wreg(8'h1E, 32'h0000_8067); idle(5);
        check("R9 low line no delivery", lg_vec.size(), 0);

        // R8 masked edge never pending
        wreg(8'h20, 32'h0001_0068);
        clear_log(); line(8, 1); idle(3);
        wreg(8'h20, 32'h0000_0068); idle(5);
        check("R8 masked edge no pending", lg_vec.size(), 0);
        line(8, 0);

        // R6 logical mode and non-fixed delivery mode are not sent
        wreg(8'h22, 32'h0000_0869);
        wreg(8'h24, 32'h0000_016A);
        clear_log(); line(9, 1); line(10, 1); idle(6);
        check("R6 non-fixed or logical silent", lg_vec.size(), 0);
        line(9, 0); line(10, 0);

        // R10 stall and lowest-first ordering
        wreg(8'h14, 32'h0000_0052); wreg(8'h15, 32'h0100_0000);
        wreg(8'h1A, 32'h0000_0055); wreg(8'h1B, 32'h0100_0000);
        wreg(8'h28, 32'h0000_005C); wreg(8'h29, 32'h0100_0000);
        clear_log();
        @(posedge clk); #2; dlv_ready = 0; irq_lines[2] = 1; irq_lines[5] = 1; irq_lines[12] = 1;
        idle(6);
        @(negedge clk);
        check("R10 stalled valid", 32'(dlv_valid), 32'h1);
        check("R10 stalled lowest first", 32'(dlv_vector), 32'h52);
        @(posedge clk); #2; dlv_ready = 1;
        idle(8);
        check("R10 three sent", lg_vec.size(), 3);
        if (lg_vec.size() == 3) begin
            check("R10 order first", 32'(lg_vec[0]), 32'h52);
            check("R10 order second", 32'(lg_vec[1]), 32'h55);
            check("R10 order third", 32'(lg_vec[2]), 32'h5C);
        end
        @(posedge clk); #2; irq_lines = '0;
        idle(3);

        // Random phase against the model
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #2;
            if ($urandom_range(0, 3) == 0) irq_lines[$urandom_range(0, 15)] ^= 1'b1;
            dlv_ready = ($urandom_range(0, 3) != 0);
            bus_req = ($urandom_range(0, 2) == 0);
            bus_we = $urandom_range(0, 1);
            case ($urandom_range(0, 5))
                0: bus_addr = 8'h04;
                1, 2: bus_addr = 8'h00;
                default: bus_addr = 8'h10;
            endcase
            bus_size = ($urandom_range(0, 7) == 0) ? 2'd1 : 2'd2;
            if (bus_addr == 8'h00)
                bus_wdata = {24'h0, 8'($urandom_range(0, 8'h31))};
            else
                bus_wdata = $urandom & 32'hFF01_89FF;
        end
        @(posedge clk); #2; bus_req = 0; dlv_ready = 1;
        idle(40);
        summary();
    end
endmodule